// File: doc/BRIEF.md
# ADC Register and Conversion Controller

This block is the register front end of a 12-bit successive-approximation converter. A processor reaches it through a simple bus with an address, a write strobe, a read strobe, write data and registered read data. The block holds these registers:

- a control register;
- positive and negative channel selects;
- two 10-bit calibration words, which are stored only;
- a status word;
- a result word;
- a write-only reset location.

The converter itself sits outside the block. It is reached through a handshake: a one-cycle start pulse out, then a done pulse and a 12-bit raw code back.

Conversions can begin only after the power-on settling interval has elapsed. The settling interval is a cycle count derived from the clock frequency and a settling time in microseconds. Each result is stored sign-extended or zero-extended in bits 27:16 of the result word. Completion sets a ready flag and pulses an interrupt. Reading the result word clears the ready flag.

Top module: `adc_reg_ctrl`

## Requirements
- R1: After reset the block is in its default state:
  - control, channel, status and result registers read 0;
  - both calibration registers read 0x200;
  - busy, start and interrupt are low.
- R2: Register map, by word offset:
  - 0 control;
  - 1 positive channel;
  - 2 negative channel;
  - 3 status (bit 0 = ready);
  - 4 result;
  - 5 offset calibration;
  - 6 gain calibration;
  - 7 reset (write-only).

  A read presents its data on the read bus in the cycle after the read strobe and zero otherwise. Unmapped offsets and offset 7 read 0.
- R3: The channel registers keep the low 5 bits of a write and the calibration registers keep the low 10 bits. Unused bits read 0. All four registers drive their output ports.
- R4: Settling:
  - The control register field layout is: bit 7 conversion enable, bit 6 converter enable, bit 5 power on (1 = normal, 0 = power-down), bits 4:3 input mode, bits 2:0 conversion type.
  - After power-on, the block waits SETTLE_US microseconds, counted in clock cycles, before it honours any start request.
  - Requests made during the wait are dropped.
  - The wait restarts whenever power is off.
- R5: A start needs conversion enable, converter enable, power on, settling complete and no conversion in flight.
  - Conversion type 001 (single) makes one request. The request is evaluated in the cycle after the control write that carries conversion enable.
  - Type 010 (continuous) requests conversions continuously.
  - Other types never start a conversion.
- R6: Busy rises together with the one-cycle start pulse. It stays high until the cycle after done is sampled. A done while not busy is ignored.
- R7: The result word holds the code in bits 27:16 and zeros in bits 15:0. For input mode 01 (differential, two's complement), bits 31:28 copy code bit 11. For modes 00, 10 and 11 (straight binary), bits 31:28 are 0. The mode is latched at start.
- R8: Completion sets status bit 0 in the cycle after done is sampled. The interrupt pulses high for that single cycle.
- R9: A read of the result word clears the ready flag, unless a completion lands in the same cycle.
- R10: Any write to offset 7 does the following:
  - returns every register to its default;
  - aborts a conversion in flight, and a later done is ignored;
  - restarts the settling wait.
- R11: In continuous mode the next start follows one cycle after busy falls. It stops once conversion enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_done | input | 1 | Converter completion pulse |
| conv_code | input | 12 | Raw converter code, valid with conv_done |
| conv_mode | output | 2 | Input mode latched for the running conversion |
| chan_pos | output | CH_W | Positive channel select |
| chan_neg | output | CH_W | Negative channel select |
| cal_offset | output | CAL_W | Offset calibration word |
| cal_gain | output | CAL_W | Gain calibration word |
| adc_busy | output | 1 | High for the duration of a conversion |
| adc_irq | output | 1 | One-cycle completion interrupt |

## Verification
Most internal faults appear at the ports within one or two cycles:

- A settling counter that expires early shows a start pulse before the expected cycle.
- A counter that never restarts after power-down shows a start where none is due.
- A wrong sign-extension or alignment corrupts the next read of the result word.
- A stuck ready flag shows in the status read that follows a result read.
- A sequencer that does not clear busy, or that accepts a stray done, shows a busy level or a result word that differs from the model in the very next cycle.

The bench compares every output against a behavioural model on every clock, so the first wrong cycle is reported.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;
  localparam int DW       = 32;
  localparam int CODE_W   = 12;
  localparam int CTRL_W   = 8;
  localparam int SIGN_W   = 4;
  localparam int LSB_PAD  = DW - SIGN_W - CODE_W;

  localparam int A_CTRL = 0;
  localparam int A_POS  = 1;
  localparam int A_NEG  = 2;
  localparam int A_STAT = 3;
  localparam int A_DATA = 4;
  localparam int A_OFS  = 5;
  localparam int A_GAIN = 6;
  localparam int A_RST  = 7;

  typedef enum logic [1:0] {
    IN_SINGLE = 2'b00,
    IN_DIFF   = 2'b01,
    IN_PSEUDO = 2'b10,
    IN_RSVD   = 2'b11
  } in_mode_e;

  typedef enum logic [2:0] {
    CT_NONE   = 3'b000,
    CT_SINGLE = 3'b001,
    CT_CONT   = 3'b010
  } conv_type_e;

  typedef struct packed {
    logic       conv_en;
    logic       adc_en;
    logic       pwr_on;
    in_mode_e   mode;
    logic [2:0] ctype;
  } ctrl_t;
endpackage

// File: rtl/adc_settle_timer.sv
module adc_settle_timer #(
  parameter int unsigned SETTLE_CYC = 62500
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic settled_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign settled_o = (cnt == LIMIT);

  // R4: settling can only complete in a cycle where the wait was not cleared
  assert_settle_no_clr_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(settled_o) |-> $past(!clr));
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_regs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     abort,
  input  logic     req,
  input  logic     gate,
  input  logic     done,
  input  in_mode_e mode_in,
  output logic     start_o,
  output logic     busy_o,
  output in_mode_e mode_o,
  output logic     accept_o
);
  assign accept_o = busy_o & done & ~abort;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      start_o <= 1'b0;
      busy_o  <= 1'b0;
      mode_o  <= IN_SINGLE;
    end else begin
      start_o <= 1'b0;
      if (!busy_o && req && gate) begin
        start_o <= 1'b1;
        busy_o  <= 1'b1;
        mode_o  <= mode_in;
      end else if (accept_o) begin
        busy_o <= 1'b0;
      end
    end
  end

  // R6: a start pulse only ever launches from idle, raising busy with it
  assert_start_from_idle_R6: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (busy_o && !$past(busy_o)));

  // R6: busy only falls after a done was seen or an abort arrived
  assert_busy_drop_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(done || abort));
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg
  import adc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              accept,
  input  logic              rd_clr,
  input  in_mode_e          mode,
  input  logic [CODE_W-1:0] code,
  output logic [DW-1:0]     data_o,
  output logic              ready_o,
  output logic              irq_o
);
  logic [SIGN_W-1:0] ext;

  always_comb ext = (mode == IN_DIFF) ? {SIGN_W{code[CODE_W-1]}} : '0;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      data_o  <= '0;
      ready_o <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= accept;
      if (accept) begin
        data_o  <= {ext, code, {LSB_PAD{1'b0}}};
        ready_o <= 1'b1;
      end else if (rd_clr) begin
        ready_o <= 1'b0;
      end
    end
  end

  // R8: the interrupt pulse coincides with a set ready flag
  assert_irq_ready_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ready_o);

  // R9: a result read without a simultaneous completion clears ready
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !accept && !clr) |=> !ready_o);

  // R7: low half stays zero and the sign nibble is all zeros or all ones
  assert_fmt_R7: assert property (@(posedge clk) disable iff (rst)
    (data_o[LSB_PAD-1:0] == '0) &&
    ((data_o[DW-1 -: SIGN_W] == '0) || (data_o[DW-1 -: SIGN_W] == '1)));
endmodule

// File: rtl/adc_reg_ctrl.sv
module adc_reg_ctrl
  import adc_regs_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int CH_W        = 5,
  parameter int CAL_W       = 10,
  parameter int CAL_DEFAULT = 512,
  parameter int CLK_FREQ_HZ = 125_000_000,
  parameter int SETTLE_US   = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              conv_start,
  input  logic              conv_done,
  input  logic [11:0]       conv_code,
  output logic [1:0]        conv_mode,
  output logic [CH_W-1:0]   chan_pos,
  output logic [CH_W-1:0]   chan_neg,
  output logic [CAL_W-1:0]  cal_offset,
  output logic [CAL_W-1:0]  cal_gain,
  output logic              adc_busy,
  output logic              adc_irq
);
  localparam int unsigned SETTLE_RAW = (CLK_FREQ_HZ / 1_000_000) * SETTLE_US;
  localparam int unsigned SETTLE_CYC = (SETTLE_RAW == 0) ? 1 : SETTLE_RAW;
  localparam logic [CAL_W-1:0] CAL_RST = CAL_W'(CAL_DEFAULT);

  ctrl_t            ctrl_q;
  ctrl_t            wd_ctrl;
  logic [CH_W-1:0]  pos_q, neg_q;
  logic [CAL_W-1:0] ofs_q, gain_q;
  logic             sw_req;
  logic             settled;
  logic             soft_rst, wr_ctrl, rd_clr;
  logic             req, gate, accept, ready;
  logic [DW-1:0]    data_q;
  in_mode_e         mode_lat;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DW-1:CAL_W];

  assign wd_ctrl  = ctrl_t'(bus_wdata[CTRL_W-1:0]);
  assign soft_rst = bus_wr && (bus_addr == ADDR_W'(A_RST));
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign rd_clr   = bus_rd && (bus_addr == ADDR_W'(A_DATA));

  // register file
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      ctrl_q <= '0;
      pos_q  <= '0;
      neg_q  <= '0;
      ofs_q  <= CAL_RST;
      gain_q <= CAL_RST;
      sw_req <= 1'b0;
    end else begin
      sw_req <= wr_ctrl && wd_ctrl.conv_en && (wd_ctrl.ctype == CT_SINGLE);
      if (wr_ctrl) ctrl_q <= wd_ctrl;
      if (bus_wr && bus_addr == ADDR_W'(A_POS))  pos_q  <= bus_wdata[CH_W-1:0];
      if (bus_wr && bus_addr == ADDR_W'(A_NEG))  neg_q  <= bus_wdata[CH_W-1:0];
      if (bus_wr && bus_addr == ADDR_W'(A_OFS))  ofs_q  <= bus_wdata[CAL_W-1:0];
      if (bus_wr && bus_addr == ADDR_W'(A_GAIN)) gain_q <= bus_wdata[CAL_W-1:0];
    end
  end

  // registered read mux
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(A_CTRL): bus_rdata <= {{(DW-CTRL_W){1'b0}}, ctrl_q};
        ADDR_W'(A_POS):  bus_rdata <= {{(DW-CH_W){1'b0}}, pos_q};
        ADDR_W'(A_NEG):  bus_rdata <= {{(DW-CH_W){1'b0}}, neg_q};
        ADDR_W'(A_STAT): bus_rdata <= {{(DW-1){1'b0}}, ready};
        ADDR_W'(A_DATA): bus_rdata <= data_q;
        ADDR_W'(A_OFS):  bus_rdata <= {{(DW-CAL_W){1'b0}}, ofs_q};
        ADDR_W'(A_GAIN): bus_rdata <= {{(DW-CAL_W){1'b0}}, gain_q};
        default:         bus_rdata <= '0;
      endcase
    end else begin
      bus_rdata <= '0;
    end
  end

  adc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk       (clk),
    .rst       (rst),
    .clr       (soft_rst || !ctrl_q.pwr_on),
    .settled_o (settled)
  );

  assign req  = sw_req || (ctrl_q.ctype == CT_CONT);
  assign gate = ctrl_q.conv_en && ctrl_q.adc_en && ctrl_q.pwr_on && settled;

  adc_conv_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .abort    (soft_rst),
    .req      (req),
    .gate     (gate),
    .done     (conv_done),
    .mode_in  (ctrl_q.mode),
    .start_o  (conv_start),
    .busy_o   (adc_busy),
    .mode_o   (mode_lat),
    .accept_o (accept)
  );

  adc_result_reg u_result (
    .clk     (clk),
    .rst     (rst),
    .clr     (soft_rst),
    .accept  (accept),
    .rd_clr  (rd_clr),
    .mode    (mode_lat),
    .code    (conv_code),
    .data_o  (data_q),
    .ready_o (ready),
    .irq_o   (adc_irq)
  );

  assign conv_mode  = mode_lat;
  assign chan_pos   = pos_q;
  assign chan_neg   = neg_q;
  assign cal_offset = ofs_q;
  assign cal_gain   = gain_q;

  // R4 R5: a start pulse needs a settled, powered, enabled converter one cycle before
  assert_no_early_start_R4: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> $past(settled && ctrl_q.pwr_on && ctrl_q.adc_en && ctrl_q.conv_en));

  // R10: a reset-register write returns control to default and drops busy
  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!adc_busy && ctrl_q == '0 && !settled));
endmodule

// File: tb/tb_adc_reg_ctrl.sv
module tb_adc_reg_ctrl;
  localparam int AW  = 4;
  localparam int LAT = 6;
  localparam int SET = 125;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          conv_start, conv_done = 1'b0;
  logic [11:0]   conv_code = '0;
  logic [1:0]    conv_mode;
  logic [4:0]    chan_pos, chan_neg;
  logic [9:0]    cal_offset, cal_gain;
  logic          adc_busy, adc_irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  adc_reg_ctrl #(.SETTLE_US(1)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_start(conv_start),
    .conv_done(conv_done), .conv_code(conv_code), .conv_mode(conv_mode),
    .chan_pos(chan_pos), .chan_neg(chan_neg), .cal_offset(cal_offset),
    .cal_gain(cal_gain), .adc_busy(adc_busy), .adc_irq(adc_irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0]  m_ctrl;
  logic [4:0]  m_pos, m_neg;
  logic [9:0]  m_ofs, m_gain;
  logic [31:0] m_data, m_rdata;
  logic        m_ready, m_busy, m_start, m_irq, m_swreq;
  logic [1:0]  m_mode;
  int          m_cnt;

  function automatic logic [31:0] fmt(input logic [1:0] md, input logic [11:0] c);
    if (md == 2'b01) return {{4{c[11]}}, c, 16'h0};
    return {4'h0, c, 16'h0};
  endfunction

  task automatic mdl_defaults();
    m_ctrl = 0; m_pos = 0; m_neg = 0; m_ofs = 10'h200; m_gain = 10'h200;
    m_data = 0; m_ready = 0; m_busy = 0; m_start = 0; m_irq = 0;
    m_swreq = 0; m_mode = 0; m_cnt = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mdl_defaults();
      m_rdata = 0;
    end else begin
      logic [7:0] oc; logic ob, osw, acc, go; int ocnt;
      oc = m_ctrl; ob = m_busy; osw = m_swreq; ocnt = m_cnt;
      if (bus_rd) begin
        case (int'(bus_addr))
          0: m_rdata = {24'h0, m_ctrl};
          1: m_rdata = {27'h0, m_pos};
          2: m_rdata = {27'h0, m_neg};
          3: m_rdata = {31'h0, m_ready};
          4: m_rdata = m_data;
          5: m_rdata = {22'h0, m_ofs};
          6: m_rdata = {22'h0, m_gain};
          default: m_rdata = 0;
        endcase
      end else m_rdata = 0;
      if (bus_wr && bus_addr == 7) begin
        mdl_defaults();
      end else begin
        acc = ob && conv_done;
        go  = !ob && (osw || oc[2:0] == 3'b010) && oc[7] && oc[6] && oc[5] && (ocnt == SET);
        m_start = go;
        m_irq = acc;
        if (go) begin m_busy = 1; m_mode = oc[4:3]; end
        else if (acc) m_busy = 0;
        if (acc) begin m_data = fmt(m_mode, conv_code); m_ready = 1; end
        else if (bus_rd && bus_addr == 4) m_ready = 0;
        if (!oc[5]) m_cnt = 0; else if (m_cnt != SET) m_cnt++;
        m_swreq = bus_wr && bus_addr == 0 && bus_wdata[7] && bus_wdata[2:0] == 3'b001;
        if (bus_wr) case (int'(bus_addr))
          0: m_ctrl = bus_wdata[7:0];
          1: m_pos  = bus_wdata[4:0];
          2: m_neg  = bus_wdata[4:0];
          5: m_ofs  = bus_wdata[9:0];
          6: m_gain = bus_wdata[9:0];
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R5 conv_start", {31'h0, conv_start}, {31'h0, m_start});
      chk("R6 adc_busy", {31'h0, adc_busy}, {31'h0, m_busy});
      chk("R8 adc_irq", {31'h0, adc_irq}, {31'h0, m_irq});
      chk("R2 bus_rdata", bus_rdata, m_rdata);
      chk("R7 conv_mode", {30'h0, conv_mode}, {30'h0, m_mode});
      chk("R3 chan_pos", {27'h0, chan_pos}, {27'h0, m_pos});
      chk("R3 chan_neg", {27'h0, chan_neg}, {27'h0, m_neg});
      chk("R3 cal_offset", {22'h0, cal_offset}, {22'h0, m_ofs});
      chk("R3 cal_gain", {22'h0, cal_gain}, {22'h0, m_gain});
    end
  end

  // converter stub
  logic [11:0] codes[$];
  int          stub_cnt = 0;
  logic [11:0] stub_code = '0;
  bit          spur = 0;

  always @(negedge clk) begin
    conv_done = 1'b0;
    if (spur) begin conv_done = 1'b1; conv_code = 12'h5A5; spur = 0; end
    if (stub_cnt > 0) begin
      stub_cnt--;
      if (stub_cnt == 0) begin conv_done = 1'b1; conv_code = stub_code; end
    end
    if (conv_start) begin
      stub_cnt = LAT;
      stub_code = (codes.size() > 0) ? codes.pop_front() : 12'h000;
    end
  end

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk); bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = AW'(a); bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int irqs;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 defaults
    rd_chk(0, 32'h0, "R1 ctrl default");
    rd_chk(5, 32'h200, "R1 offset default");
    rd_chk(6, 32'h200, "R1 gain default");
    rd_chk(3, 32'h0, "R1 status default");
    rd_chk(4, 32'h0, "R1 data default");
    chk("R1 busy default", {31'h0, adc_busy}, 32'h0);

    // R3 widths, R2 map
    wr_reg(1, 32'hFFFF_FFE3);
    rd_chk(1, 32'h03, "R3 pos channel width");
    wr_reg(2, 32'h12);
    rd_chk(2, 32'h12, "R3 neg channel");
    wr_reg(5, 32'hFFFF_F155);
    rd_chk(5, 32'h155, "R3 offset width");
    wr_reg(6, 32'h0AA);
    rd_chk(6, 32'h0AA, "R3 gain");
    chk("R3 chan_pos port", {27'h0, chan_pos}, 32'h3);
    rd_chk(9, 32'h0, "R2 unmapped offset");
    rd_chk(7, 32'h0, "R2 reset offset reads zero");

    // R4 request before settling is dropped
    codes.push_back(12'h800);
    wr_reg(0, 32'hE9);
    idle(20);
    chk("R4 no start before settle", {31'h0, adc_busy}, 32'h0);
    rd_chk(3, 32'h0, "R4 status idle before settle");
    rd_chk(0, 32'hE9, "R2 ctrl readback");
    idle(SET + 10);

    // R5 R6 R7 R8 R9 differential negative
    wr_reg(0, 32'hE9);
    @(negedge clk);
    chk("R6 busy with start", {30'h0, adc_busy, conv_start}, 32'h3);
    idle(LAT + 4);
    chk("R6 busy after done", {31'h0, adc_busy}, 32'h0);
    rd_chk(3, 32'h1, "R8 ready set");
    rd_chk(4, 32'hF800_0000, "R7 diff negative");
    rd_chk(3, 32'h0, "R9 ready cleared by read");

    codes.push_back(12'h7FF);
    wr_reg(0, 32'hE9); idle(LAT + 4);
    rd_chk(4, 32'h07FF_0000, "R7 diff positive");

    codes.push_back(12'hABC);
    wr_reg(0, 32'hE1); idle(LAT + 4);
    rd_chk(4, 32'h0ABC_0000, "R7 single-ended binary");

    codes.push_back(12'hFFF);
    wr_reg(0, 32'hF1); idle(LAT + 4);
    rd_chk(4, 32'h0FFF_0000, "R7 pseudo-differential binary");

    codes.push_back(12'h900);
    wr_reg(0, 32'hF9); idle(LAT + 4);
    rd_chk(4, 32'h0900_0000, "R7 reserved mode binary");

    // R5 gating
    wr_reg(0, 32'hA1); idle(LAT + 4);
    chk("R5 no start without converter enable", {31'h0, adc_busy}, 32'h0);
    rd_chk(3, 32'h0, "R5 status after disabled request");
    wr_reg(0, 32'hE0); idle(LAT + 4);
    rd_chk(3, 32'h0, "R5 type none never starts");

    // R6 stray done
    spur = 1;
    idle(4);
    rd_chk(3, 32'h0, "R6 stray done ignored status");
    rd_chk(4, 32'h0900_0000, "R6 stray done ignored data");

    // R11 continuous
    codes.push_back(12'h111); codes.push_back(12'h222); codes.push_back(12'h333);
    wr_reg(0, 32'hE2);
    irqs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (adc_irq) irqs++;
    end
    chk("R11 continuous completions", {31'h0, irqs >= 3}, 32'h1);
    chk("R11 code queue drained", codes.size(), 32'h0);
    wr_reg(0, 32'h62);
    idle(LAT + 6);
    chk("R11 stops when disabled", {31'h0, adc_busy}, 32'h0);
    @(negedge clk); bus_addr = 4; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;

    // R4 settle restarts after power-down
    wr_reg(0, 32'h40); idle(3);
    wr_reg(0, 32'hE1); idle(LAT);
    chk("R4 settle restarted", {31'h0, adc_busy}, 32'h0);
    idle(SET + 5);
    codes.push_back(12'h321);
    wr_reg(0, 32'hE1); idle(LAT + 4);
    rd_chk(4, 32'h0321_0000, "R4 conversion after resettle");

    // R10 soft reset mid-conversion
    codes.push_back(12'h456);
    wr_reg(0, 32'hE1);
    @(negedge clk);
    chk("R10 busy before soft reset", {31'h0, adc_busy}, 32'h1);
    wr_reg(7, 32'h0);
    chk("R10 busy aborted", {31'h0, adc_busy}, 32'h0);
    idle(LAT + 4);
    rd_chk(3, 32'h0, "R10 status default, late done ignored");
    rd_chk(4, 32'h0, "R10 data default");
    rd_chk(0, 32'h0, "R10 ctrl default");
    rd_chk(5, 32'h200, "R10 offset default");
    rd_chk(1, 32'h0, "R10 channel default");
    wr_reg(0, 32'hE1); idle(LAT);
    chk("R10 settle wait restarted", {31'h0, adc_busy}, 32'h0);

    idle(4);
    finish_run();
  end
endmodule